// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave Command Engine

This block is the command engine of a 256-byte serial EEPROM that sits on a two-wire bus. It runs entirely in a system clock domain. The clock line and the data line are taken in as plain inputs. They are synchronised and majority-filtered, then turned into clock edges and START/STOP events. The engine answers with a single open-drain enable: when the enable is high, the data line is pulled low. The array itself is outside the engine. The engine presents a read address and takes read data back. It hands each received write byte out with a strobe, and it signals a commit when the write command closes with a STOP. An external store raises `busy` for the length of its write cycle.

A host selects the device with a slave byte. The slave byte carries a fixed type nibble, then a three-bit device number that must equal the `dev_sel` pins, then a read/write flag. A write command carries a word address and then data bytes. The word address is also used on its own as the first half of a random read. A single address counter persists across commands. Reads begin at that counter and continue for as long as the host acknowledges. While the external write cycle runs, every slave byte is refused with a NACK, so the host can poll for completion.

Top module: `twe_engine`

## Requirements
- R1: After reset the engine is idle: `sda_oe`=0, `wr_stb`=0, `wr_commit`=0 and the address counter `rd_addr`=00h. A STOP (data rising while clock high) returns the engine to idle and releases `sda_oe` within a cycle. A START (data falling while clock high) restarts slave-byte reception from any state.
- R2: Slave byte bits [7:4] must be 1010b and bits [3:1] must equal `dev_sel`; bit 0 set means read. Only a matching byte is acknowledged. Any other byte is left unanswered, and the engine ignores the bus until the next START.
- R3: An acknowledge drives `sda_oe` high from the clock falling edge after the eighth bit to the following falling edge, and low outside that slot.
- R4: The byte after a write slave byte is a word address. It is acknowledged and loaded into the address counter.
- R5: Every later write byte is acknowledged and handed out by a one-cycle `wr_stb` with `wr_addr` = counter and `wr_data` = byte. Only the low 4 counter bits then increment, wrapping within the 16-byte page.
- R6: `wr_commit` pulses for one cycle on a STOP only if at least one write byte arrived since the last START. A repeated START discards the pending bytes without a commit.
- R7: A read sends the byte at the counter, most significant bit first, with each bit changing just after a clock falling edge. A random read is a write slave byte, a word address, a repeated START and a read slave byte.
- R8: Each fully sent read byte advances the counter by one, wrapping FFh to 00h. A current read therefore returns the byte after the last one accessed.
- R9: A low acknowledge from the host after a read byte starts the next byte. A high acknowledge makes the engine release the line and ignore all clocks until START or STOP.
- R10: While `busy` is high, no slave byte is acknowledged and the address counter is left unchanged.
- R11: A START followed by a STOP partway through the slave byte cancels the command: no acknowledge, no strobe, no commit, and the counter is unchanged.
- R12: A pulse of one system clock on either bus line is filtered out and changes no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled at the pad |
| sda_i | input | 1 | Bus data line as sampled at the pad |
| dev_sel | input | 3 | Device number this engine answers to |
| busy | input | 1 | External write cycle in progress |
| sda_oe | output | 1 | High pulls the data line low |
| rd_addr | output | 8 | Address counter, read address to the array |
| rd_data | input | 8 | Byte at `rd_addr` from the array |
| wr_stb | output | 1 | One-cycle strobe per received write byte |
| wr_addr | output | 8 | Address for the strobed byte |
| wr_data | output | 8 | Strobed write byte |
| wr_commit | output | 1 | One-cycle pulse: write command closed by STOP |

## Verification
A pad change reaches the filtered line after five system clocks, so `sda_oe` moves on the sixth clock after the bus clock edge that causes it. A strobe or commit appears on that same clock. The bench holds every bus phase for ten system clocks and samples the acknowledge and the read data in the middle of the clock-high phase. It checks the strobe log and the commit count a full phase after the byte or STOP that produces them, so each result is already settled when it is read. It also checks `sda_oe` one phase before and one phase after the acknowledge slot, which pins the drive window to the two falling edges that bound it.

// File: rtl/twe_pkg.sv
package twe_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RX,
    S_RXACK,
    S_TX,
    S_TXACK,
    S_HOLD
  } twe_state_e;

  typedef enum logic [1:0] {
    K_DEV,
    K_WADDR,
    K_DATA
  } twe_kind_e;

  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

endpackage

// File: rtl/twe_line_filter.sv
module twe_line_filter #(
  parameter int LINES       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [SYNC_STAGES-1:0] sync_q;
    logic [2:0]             hist_q;
    logic                   out_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sync_q <= '1;
        hist_q <= '1;
        out_q  <= 1'b1;
      end else begin
        sync_q <= {sync_q[SYNC_STAGES-2:0], din[g]};
        hist_q <= {hist_q[1:0], sync_q[SYNC_STAGES-1]};
        out_q  <= twe_pkg::maj3(hist_q);
      end
    end

    assign dout[g] = out_q;
  end

endmodule

// File: rtl/twe_bus_events.sv
module twe_bus_events (
  input  logic clk,
  input  logic rst,
  input  logic scl,
  input  logic sda,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda;
  assign stop_det  = scl & scl_q & ~sda_q & sda;

endmodule

// File: rtl/twe_engine.sv
module twe_engine #(
  parameter int         ADDR_W      = 8,
  parameter int         PAGE_W      = 4,
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] TYPE_CODE   = 4'hA
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  input  logic [2:0]        dev_sel,
  input  logic              busy,
  output logic              sda_oe,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [7:0]        rd_data,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              wr_commit
);
  import twe_pkg::*;

  localparam int         CNT_W = 4;
  localparam logic [CNT_W-1:0] BITS_DONE = CNT_W'(8);

  logic [1:0] line_f;
  logic       scl_f;
  logic       sda_f;
  logic       scl_rise;
  logic       scl_fall;
  logic       start_det;
  logic       stop_det;

  twe_line_filter #(
    .LINES       (2),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_filter (
    .clk  (clk),
    .rst  (rst),
    .din  ({scl_i, sda_i}),
    .dout (line_f)
  );

  assign scl_f = line_f[1];
  assign sda_f = line_f[0];

  twe_bus_events u_events (
    .clk       (clk),
    .rst       (rst),
    .scl       (scl_f),
    .sda       (sda_f),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  twe_state_e        state;
  twe_kind_e         kind;
  logic [CNT_W-1:0]  cnt;
  logic [7:0]        sh;
  logic [ADDR_W-1:0] addr;
  logic              rw;
  logic              host_ack;
  logic              pend;
  logic              oe;
  logic              byte_in;
  logic              dev_eval;
  logic              dev_match;
  logic              tx_done;

  assign byte_in   = (state == S_RX) && scl_fall && (cnt == BITS_DONE);
  assign dev_eval  = byte_in && (kind == K_DEV);
  assign dev_match = (sh[7:4] == TYPE_CODE) && (sh[3:1] == dev_sel) && !busy;
  assign tx_done   = (state == S_TX) && scl_fall && (cnt == BITS_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_IDLE;
      kind      <= K_DEV;
      cnt       <= '0;
      sh        <= '0;
      addr      <= '0;
      rw        <= 1'b0;
      host_ack  <= 1'b0;
      pend      <= 1'b0;
      oe        <= 1'b0;
      wr_stb    <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_stb    <= 1'b0;
      wr_commit <= 1'b0;
      if (stop_det) begin
        state     <= S_IDLE;
        oe        <= 1'b0;
        wr_commit <= pend;
        pend      <= 1'b0;
      end else if (start_det) begin
        state <= S_RX;
        kind  <= K_DEV;
        cnt   <= '0;
        oe    <= 1'b0;
        pend  <= 1'b0;
      end else begin
        case (state)
          S_RX: begin
            if (scl_rise) begin
              sh  <= {sh[6:0], sda_f};
              cnt <= cnt + 1'b1;
            end else if (byte_in) begin
              case (kind)
                K_DEV: begin
                  if (dev_match) begin
                    rw    <= sh[0];
                    oe    <= 1'b1;
                    state <= S_RXACK;
                  end else begin
                    state <= S_HOLD;
                  end
                end
                K_WADDR: begin
                  addr  <= sh[ADDR_W-1:0];
                  oe    <= 1'b1;
                  state <= S_RXACK;
                end
                default: begin
                  wr_stb  <= 1'b1;
                  wr_addr <= addr;
                  wr_data <= sh;
                  addr    <= {addr[ADDR_W-1:PAGE_W], addr[PAGE_W-1:0] + 1'b1};
                  pend    <= 1'b1;
                  oe      <= 1'b1;
                  state   <= S_RXACK;
                end
              endcase
            end
          end
          S_RXACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == K_DEV && rw) begin
                sh    <= rd_data;
                oe    <= ~rd_data[7];
                state <= S_TX;
              end else begin
                oe    <= 1'b0;
                kind  <= (kind == K_DEV) ? K_WADDR : K_DATA;
                state <= S_RX;
              end
            end
          end
          S_TX: begin
            if (scl_rise) begin
              cnt <= cnt + 1'b1;
            end else if (tx_done) begin
              oe    <= 1'b0;
              addr  <= addr + 1'b1;
              state <= S_TXACK;
            end else if (scl_fall) begin
              sh <= {sh[6:0], 1'b0};
              oe <= ~sh[6];
            end
          end
          S_TXACK: begin
            if (scl_rise) begin
              host_ack <= ~sda_f;
            end else if (scl_fall) begin
              if (host_ack) begin
                sh    <= rd_data;
                oe    <= ~rd_data[7];
                cnt   <= '0;
                state <= S_TX;
              end else begin
                state <= S_HOLD;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe  = oe;
  assign rd_addr = addr;

endmodule

// File: rtl/twe_engine_chk.sv
module twe_engine_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sda_oe,
  input logic              scl_f,
  input logic              stop_det,
  input logic              dev_eval,
  input logic              busy,
  input logic              wr_stb,
  input logic              wr_commit,
  input logic              tx_done,
  input logic [ADDR_W-1:0] rd_addr
);

  // R1
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> !sda_oe);

  // R3
  oe_rise_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> !scl_f);

  // R10
  busy_nack_chk: assert property (@(posedge clk) disable iff (rst)
    (dev_eval && busy) |=> !sda_oe);

  // R5
  stb_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    wr_stb |=> !wr_stb);

  // R6
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> $past(stop_det));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (rst)
    tx_done |=> (rd_addr == $past(rd_addr) + 1'b1));

endmodule

bind twe_engine twe_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .sda_oe    (sda_oe),
  .scl_f     (scl_f),
  .stop_det  (stop_det),
  .dev_eval  (dev_eval),
  .busy      (busy),
  .wr_stb    (wr_stb),
  .wr_commit (wr_commit),
  .tx_done   (tx_done),
  .rd_addr   (rd_addr)
);

// File: tb/twe_engine_test.sv
module twe_engine_test;

  localparam int Q         = 10;
  localparam int BUSY_CLKS = 2000;
  localparam logic [2:0] DEV  = 3'b101;
  localparam logic [7:0] DEVW = {4'hA, DEV, 1'b0};
  localparam logic [7:0] DEVR = {4'hA, DEV, 1'b1};

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst = 1'b1;
  logic       scl = 1'b1;
  logic       host_sda = 1'b1;
  logic       busy;
  logic       sda_oe;
  logic [7:0] rd_addr;
  logic [7:0] rd_data;
  logic       wr_stb;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;
  logic       wr_commit;
  wire        sda_line = host_sda & ~sda_oe;

  int checks = 0;
  int errors = 0;

  twe_engine uut (
    .clk       (clk),
    .rst       (rst),
    .scl_i     (scl),
    .sda_i     (sda_line),
    .dev_sel   (DEV),
    .busy      (busy),
    .sda_oe    (sda_oe),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .wr_commit (wr_commit)
  );

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 37 + 11) % 256);
  endfunction

  // external array, write log, commit count and write-cycle model
  logic [7:0] mem [256];
  logic [7:0] log_addr [64];
  logic [7:0] log_data [64];
  int         nlog = 0;
  int         commits = 0;
  int         busy_cnt = 0;
  logic       oe_seen = 1'b0;
  logic       clr_seen = 1'b0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
    end else if (wr_stb) begin
      mem[wr_addr]   <= wr_data;
      log_addr[nlog] <= wr_addr;
      log_data[nlog] <= wr_data;
      nlog           <= nlog + 1;
    end
    if (wr_commit) begin
      commits  <= commits + 1;
      busy_cnt <= BUSY_CLKS;
    end else if (busy_cnt != 0) begin
      busy_cnt <= busy_cnt - 1;
    end
    if (clr_seen) oe_seen <= 1'b0;
    else if (sda_oe) oe_seen <= 1'b1;
  end

  assign busy    = (busy_cnt != 0);
  assign rd_data = mem[rd_addr];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n = 1);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic clear_seen();
    @(negedge clk) clr_seen = 1'b1;
    @(negedge clk) clr_seen = 1'b0;
  endtask

  task automatic bus_start();
    host_sda = 1'b1; wq();
    scl = 1'b1;      wq();
    host_sda = 1'b0; wq();
    scl = 1'b0;      wq();
  endtask

  task automatic bus_stop();
    host_sda = 1'b0; wq();
    scl = 1'b1;      wq();
    host_sda = 1'b1; wq(2);
  endtask

  task automatic send_bit(input logic b, input logic gsda, input logic gscl, output logic oe_hi);
    host_sda = b; wq();
    scl = 1'b1;   wq();
    oe_hi = sda_oe;
    if (gsda) begin
      @(negedge clk) host_sda = ~b;
      @(negedge clk) host_sda = b;
    end
    if (gscl) begin
      @(negedge clk) scl = 1'b0;
      @(negedge clk) scl = 1'b1;
    end
    wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic [7:0] gs, input logic [7:0] gc,
                           output logic ack, output logic pre_oe, output logic mid_oe,
                           output logic post_oe);
    logic oh;
    for (int i = 7; i >= 0; i--) send_bit(v[i], gs[i], gc[i], oh);
    pre_oe   = oh;
    host_sda = 1'b1;
    mid_oe   = sda_oe;
    wq();
    scl = 1'b1; wq();
    ack = ~sda_line;
    wq();
    scl = 1'b0; wq();
    post_oe = sda_oe;
  endtask

  task automatic wbyte(input logic [7:0] v, output logic ack);
    logic a, b, c;
    send_byte(v, 8'h00, 8'h00, ack, a, b, c);
  endtask

  task automatic recv_byte(input logic ack_low, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      host_sda = 1'b1; wq();
      scl = 1'b1;      wq();
      v = {v[6:0], sda_line};
      wq();
      scl = 1'b0;      wq();
    end
    host_sda = ~ack_low; wq();
    scl = 1'b1;          wq(2);
    scl = 1'b0;          wq();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : script
    logic       ack, pre, mid, post, bit_hi;
    logic [7:0] v;
    int         base;

    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R1 reset wr_stb", wr_stb, 0);
    chk("R1 reset wr_commit", wr_commit, 0);
    chk("R1 reset counter", rd_addr, 8'h00);

    // R2: sweep of every device number, R3 acknowledge window
    for (int t = 0; t < 8; t++) begin
      bus_start();
      send_byte({4'hA, 3'(t), 1'b0}, 8'h00, 8'h00, ack, pre, mid, post);
      chk($sformatf("R2 device number %0d ack", t), ack, (3'(t) == DEV));
      if (3'(t) == DEV) begin
        chk("R3 released during bit 0", pre, 0);
        chk("R3 driven after falling edge", mid, 1);
        chk("R3 released after ack slot", post, 0);
      end
      bus_stop();
    end
    bus_start();
    wbyte({4'h6, DEV, 1'b0}, ack);
    chk("R2 wrong type nibble nack", ack, 0);
    bus_stop();

    // R4 R7: random read at 3Ch
    bus_start();
    wbyte(DEVW, ack);
    wbyte(8'h3C, ack);
    chk("R4 word address ack", ack, 1);
    bus_start();
    wbyte(DEVR, ack);
    chk("R2 read slave byte ack", ack, 1);
    recv_byte(1'b0, v);
    chk("R7 random read data", v, pat(8'h3C));
    bus_stop();

    // R8: current read follows last access
    bus_start();
    wbyte(DEVR, ack);
    recv_byte(1'b0, v);
    chk("R8 current read data", v, pat(8'h3D));
    bus_stop();

    // R9 R8: sequential read across FFh
    bus_start();
    wbyte(DEVW, ack);
    wbyte(8'hFE, ack);
    bus_start();
    wbyte(DEVR, ack);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k < 3, v);
      chk($sformatf("R9 sequential byte %0d", k), v, pat((254 + k) % 256));
    end
    clear_seen();
    recv_byte(1'b0, v);
    chk("R9 ignored after nack line", v, 8'hFF);
    chk("R9 ignored after nack drive", oe_seen, 0);
    bus_stop();
    bus_start();
    wbyte(DEVR, ack);
    recv_byte(1'b0, v);
    chk("R8 counter wrapped", v, pat(2));
    bus_stop();

    // R5 R6: page write with in-page wrap
    base = nlog;
    bus_start();
    wbyte(DEVW, ack);
    wbyte(8'h5D, ack);
    for (int k = 0; k < 5; k++) begin
      wbyte(8'hC0 + 8'(k), ack);
      chk($sformatf("R5 data ack %0d", k), ack, 1);
      chk($sformatf("R5 strobe addr %0d", k), log_addr[base + k], {4'h5, 4'(13 + k)});
      chk($sformatf("R5 strobe data %0d", k), log_data[base + k], 8'hC0 + 8'(k));
    end
    chk("R5 strobe count", nlog - base, 5);
    bus_stop();
    wq();
    chk("R6 commit on stop", commits, 1);

    // R10: refused while busy
    chk("R10 busy raised", busy, 1);
    bus_start();
    wbyte(DEVW, ack);
    chk("R10 write nack while busy", ack, 0);
    bus_start();
    wbyte(DEVR, ack);
    chk("R10 read nack while busy", ack, 0);
    bus_stop();
    while (busy) @(negedge clk);
    bus_start();
    wbyte(DEVR, ack);
    chk("R10 ack after busy", ack, 1);
    recv_byte(1'b0, v);
    chk("R10 counter kept", v, pat(8'h52));
    bus_stop();

    bus_start();
    wbyte(DEVW, ack);
    wbyte(8'h50, ack);
    bus_start();
    wbyte(DEVR, ack);
    recv_byte(1'b1, v);
    chk("R5 wrapped byte stored", v, 8'hC3);
    recv_byte(1'b0, v);
    chk("R5 next wrapped byte", v, 8'hC4);
    bus_stop();

    // R6: repeated START discards pending writes
    bus_start();
    wbyte(DEVW, ack);
    wbyte(8'h20, ack);
    wbyte(8'hAA, ack);
    bus_start();
    wbyte(DEVR, ack);
    recv_byte(1'b0, v);
    chk("R6 read after dropped write", v, pat(8'h21));
    bus_stop();
    wq();
    chk("R6 no commit after restart", commits, 1);
    chk("R6 no busy after restart", busy, 0);

    // R11: START then STOP inside the slave byte
    base = nlog;
    clear_seen();
    bus_start();
    send_bit(1'b1, 1'b0, 1'b0, bit_hi);
    send_bit(1'b0, 1'b0, 1'b0, bit_hi);
    send_bit(1'b1, 1'b0, 1'b0, bit_hi);
    send_bit(1'b0, 1'b0, 1'b0, bit_hi);
    bus_stop();
    chk("R11 no drive", oe_seen, 0);
    chk("R11 no strobe", nlog - base, 0);
    chk("R11 no commit", commits, 1);
    bus_start();
    wbyte(DEVR, ack);
    recv_byte(1'b0, v);
    chk("R11 counter unchanged", v, pat(8'h22));
    bus_stop();

    // R12: single-clock glitches on data and clock
    base = nlog;
    bus_start();
    wbyte(DEVW, ack);
    send_byte(8'hC4, 8'h80, 8'h04, ack, pre, mid, post);
    chk("R12 word address ack after glitches", ack, 1);
    wbyte(8'h5A, ack);
    chk("R12 data ack", ack, 1);
    chk("R12 strobe addr", log_addr[base], 8'hC4);
    chk("R12 strobe data", log_data[base], 8'h5A);
    bus_stop();
    wq();
    chk("R12 commit", commits, 2);
    while (busy) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule